// File: doc/BRIEF.md
# MOESI Snooping Coherence Controller

This block keeps the coherence state of every line in a small direct-indexed private cache that sits on a shared snooping bus. Each line holds one data word, a tag and one of five states: Modified, Owned, Exclusive, Shared or Invalid. The local processor sends read and write requests. The controller answers hits on its own. On a miss or an upgrade it places a single transaction on the bus and waits for the bus to report completion. When a dirty victim is displaced, a writeback is placed on the bus ahead of the fill.

At the same time the controller watches the transactions of other agents. For each one it reports whether it holds a copy (shared). When its copy is the only current one, it also drives an intervention flag and supplies the data word. A dirty line that another agent reads moves to Owned. Memory is not updated, and the line keeps supplying data to later readers. Bus arbitration, memory and the other caches are outside the block.

Bus command codes, used on both the request and the snoop side: 0 = read, 1 = read-for-ownership, 2 = upgrade, 3 = writeback. The low log2(NUM_LINES) address bits index the line and the remaining bits form the tag.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `req_ready_o` is high, and `bus_req_valid_o` and `rsp_valid_o` are low. A snoop to any address asserts neither shared nor intervention.
- R2: A local read miss issues command 0 for the request address. At completion the line becomes Exclusive if `bus_shared_i` was low and Shared if it was high. The fill word is returned on `rsp_rdata_o` in the cycle after completion.
- R3: A local read that hits in Shared, Exclusive, Owned or Modified returns the stored word with `rsp_valid_o` in the cycle after acceptance. It issues no bus request and changes no state.
- R4: A local write to an Exclusive line makes it Modified with no bus request, and the response follows in the next cycle.
- R5: A local write to a Shared or Owned line issues command 2. On completion the line becomes Modified with the new word, and the response follows one cycle later.
- R6: A local write miss issues command 1 and installs the line as Modified holding the written word.
- R7: A snooped read (0) that hits Modified asserts shared and intervention, supplies the word and moves the line to Owned. Later snooped reads of the Owned line again assert intervention with the word.
- R8: A snooped read that hits Exclusive asserts shared without intervention and moves the line to Shared. One that hits Shared asserts shared and leaves the line Shared.
- R9: A snooped read-for-ownership (1) or upgrade (2) invalidates a hit line. Read-for-ownership on Modified or Owned first supplies the word with intervention.
- R10: A miss whose victim is Modified or Owned first issues command 3 with the victim's address and word, then the fill. A Shared or Exclusive victim is dropped without a bus request. A request's command and address stay stable until completion.
- R11: `req_ready_o` is low while a bus transaction of this cache is outstanding, and also in any cycle with `snp_valid_i` high. In those cycles the snoop is served first.
- R12: If an upgrade's line is invalidated by a snoop before the upgrade completes, completion is followed by a read-for-ownership (1) of the same address. That transaction ends with the line Modified holding the written word.
- R13: A snoop whose address does not match a valid line asserts neither shared nor intervention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write word |
| req_ready_o | output | 1 | Request accepted at this edge when high |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | DATA_W | Read word (or the written word for writes) |
| bus_req_valid_o | output | 1 | Own bus transaction outstanding |
| bus_req_cmd_o | output | 2 | Own bus command |
| bus_req_addr_o | output | ADDR_W | Own bus address |
| bus_req_data_o | output | DATA_W | Writeback word |
| bus_done_i | input | 1 | Own transaction completes at this edge |
| bus_shared_i | input | 1 | Another cache holds the line (for reads) |
| bus_fill_data_i | input | DATA_W | Fill word at completion |
| snp_valid_i | input | 1 | Other agent's transaction visible |
| snp_cmd_i | input | 2 | Snooped command |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | This cache keeps a copy |
| snp_inter_o | output | 1 | This cache supplies the data |
| snp_data_o | output | DATA_W | Supplied word |

## Verification
Snoop outputs are combinational, so the bench reads them one time unit after driving a snoop at the falling edge. The resulting state change is checked through later snoops or requests. A hit's response and a new bus request both appear in the cycle after the accepting rising edge. A completion's response or follow-on request appears in the cycle after the edge that samples `bus_done_i`. The bench therefore drives at each falling edge and samples shortly after the next falling edge, never at a rising edge. Every state the requirements name is confirmed at the ports: Shared versus Exclusive by whether a later write goes to the bus, and Owned by a repeated intervention.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {ST_I, ST_S, ST_E, ST_O, ST_M} line_st_e;
  typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPG = 2'd2, CMD_WB = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {LC_IDLE, LC_WB, LC_FILL, LC_UPG} lc_st_e;
endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3,
  parameter int TAG_W     = 9,
  parameter int DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  la_idx_i,
  output logic [TAG_W-1:0]  la_tag_o,
  output line_st_e          la_st_o,
  output logic [DATA_W-1:0] la_data_o,
  input  logic [IDX_W-1:0]  sn_idx_i,
  output logic [TAG_W-1:0]  sn_tag_o,
  output line_st_e          sn_st_o,
  output logic [DATA_W-1:0] sn_data_o,
  input  logic              lw_en_i,
  input  logic [IDX_W-1:0]  lw_idx_i,
  input  logic [TAG_W-1:0]  lw_tag_i,
  input  line_st_e          lw_st_i,
  input  logic              lw_data_en_i,
  input  logic [DATA_W-1:0] lw_data_i,
  input  logic              sw_en_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  line_st_e          sw_st_i
);
  logic [TAG_W-1:0]  tag_q  [NUM_LINES];
  line_st_e          st_q   [NUM_LINES];
  logic [DATA_W-1:0] data_q [NUM_LINES];

  assign la_tag_o  = tag_q[la_idx_i];
  assign la_st_o   = st_q[la_idx_i];
  assign la_data_o = data_q[la_idx_i];
  assign sn_tag_o  = tag_q[sn_idx_i];
  assign sn_st_o   = st_q[sn_idx_i];
  assign sn_data_o = data_q[sn_idx_i];

  // snoop update is applied last so it wins on a shared index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        tag_q[i]  <= '0;
        st_q[i]   <= ST_I;
        data_q[i] <= '0;
      end
    end else begin
      if (lw_en_i) begin
        tag_q[lw_idx_i] <= lw_tag_i;
        st_q[lw_idx_i]  <= lw_st_i;
      end
      if (lw_en_i && lw_data_en_i) data_q[lw_idx_i] <= lw_data_i;
      if (sw_en_i) st_q[sw_idx_i] <= sw_st_i;
    end
  end
endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
  import moesi_pkg::*;
#(
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              inter_o,
  output logic [DATA_W-1:0] data_o,
  output logic              upd_en_o,
  output line_st_e          upd_st_o
);
  logic hit, dirty;

  assign hit   = snp_valid_i && (line_st_i != ST_I) && (line_tag_i == snp_tag_i);
  assign dirty = (line_st_i == ST_M) || (line_st_i == ST_O);

  always_comb begin
    shared_o = 1'b0;
    inter_o  = 1'b0;
    upd_en_o = 1'b0;
    upd_st_o = ST_I;
    if (hit) begin
      case (snp_cmd_i)
        CMD_RD: begin
          shared_o = 1'b1;
          inter_o  = dirty;
          if (line_st_i == ST_M) begin
            upd_en_o = 1'b1;
            upd_st_o = ST_O;
          end else if (line_st_i == ST_E) begin
            upd_en_o = 1'b1;
            upd_st_o = ST_S;
          end
        end
        CMD_RDX: begin
          inter_o  = dirty;
          upd_en_o = 1'b1;
        end
        CMD_UPG: upd_en_o = 1'b1;
        default: ;
      endcase
    end
  end

  assign data_o = inter_o ? line_data_i : '0;
endmodule

// File: rtl/moesi_local_ctrl.sv
module moesi_local_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              snp_valid_i,
  input  logic              bus_done_i,
  input  logic              bus_shared_i,
  input  logic [DATA_W-1:0] bus_fill_data_i,
  output logic              bus_req_valid_o,
  output logic [1:0]        bus_req_cmd_o,
  output logic [ADDR_W-1:0] bus_req_addr_o,
  output logic [DATA_W-1:0] bus_req_data_o,
  output logic [IDX_W-1:0]  la_idx_o,
  input  logic [TAG_W-1:0]  la_tag_i,
  input  line_st_e          la_st_i,
  input  logic [DATA_W-1:0] la_data_i,
  output logic              lw_en_o,
  output logic [TAG_W-1:0]  lw_tag_o,
  output line_st_e          lw_st_o,
  output logic              lw_data_en_o,
  output logic [DATA_W-1:0] lw_data_o
);
  lc_st_e            st_q, st_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic              pend_wr_q, pend_wr_d;
  logic [DATA_W-1:0] pend_wdata_q, pend_wdata_d;
  logic              rsp_q, rsp_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              l_hit, accept;

  assign cur_addr    = (st_q == LC_IDLE) ? req_addr_i : pend_addr_q;
  assign la_idx_o    = cur_addr[IDX_W-1:0];
  assign cur_tag     = cur_addr[ADDR_W-1:IDX_W];
  assign l_hit       = (la_st_i != ST_I) && (la_tag_i == cur_tag);
  assign req_ready_o = (st_q == LC_IDLE) && !snp_valid_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    st_d         = st_q;
    pend_addr_d  = pend_addr_q;
    pend_wr_d    = pend_wr_q;
    pend_wdata_d = pend_wdata_q;
    rsp_d        = 1'b0;
    rdata_d      = rdata_q;
    lw_en_o      = 1'b0;
    lw_tag_o     = cur_tag;
    lw_st_o      = ST_I;
    lw_data_en_o = 1'b0;
    lw_data_o    = '0;
    case (st_q)
      LC_IDLE: if (accept) begin
        pend_addr_d  = req_addr_i;
        pend_wr_d    = req_write_i;
        pend_wdata_d = req_wdata_i;
        if (l_hit) begin
          if (!req_write_i) begin
            rsp_d   = 1'b1;
            rdata_d = la_data_i;
          end else if (la_st_i == ST_M || la_st_i == ST_E) begin
            lw_en_o      = 1'b1;
            lw_st_o      = ST_M;
            lw_data_en_o = 1'b1;
            lw_data_o    = req_wdata_i;
            rsp_d        = 1'b1;
            rdata_d      = req_wdata_i;
          end else begin
            st_d = LC_UPG;
          end
        end else if (la_st_i == ST_M || la_st_i == ST_O) begin
          st_d = LC_WB;
        end else begin
          st_d = LC_FILL;
        end
      end
      LC_WB: if (bus_done_i) begin
        lw_en_o  = 1'b1;
        lw_tag_o = la_tag_i;
        lw_st_o  = ST_I;
        st_d     = LC_FILL;
      end
      LC_FILL: if (bus_done_i) begin
        lw_en_o      = 1'b1;
        lw_st_o      = pend_wr_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
        lw_data_en_o = 1'b1;
        lw_data_o    = pend_wr_q ? pend_wdata_q : bus_fill_data_i;
        rsp_d        = 1'b1;
        rdata_d      = lw_data_o;
        st_d         = LC_IDLE;
      end
      LC_UPG: if (bus_done_i) begin
        if (l_hit) begin
          lw_en_o      = 1'b1;
          lw_st_o      = ST_M;
          lw_data_en_o = 1'b1;
          lw_data_o    = pend_wdata_q;
          rsp_d        = 1'b1;
          rdata_d      = pend_wdata_q;
          st_d         = LC_IDLE;
        end else begin
          st_d = LC_FILL;  // copy lost while waiting: fetch ownership
        end
      end
      default: st_d = LC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= LC_IDLE;
      pend_addr_q  <= '0;
      pend_wr_q    <= 1'b0;
      pend_wdata_q <= '0;
      rsp_q        <= 1'b0;
      rdata_q      <= '0;
    end else begin
      st_q         <= st_d;
      pend_addr_q  <= pend_addr_d;
      pend_wr_q    <= pend_wr_d;
      pend_wdata_q <= pend_wdata_d;
      rsp_q        <= rsp_d;
      rdata_q      <= rdata_d;
    end
  end

  assign rsp_valid_o     = rsp_q;
  assign rsp_rdata_o     = rdata_q;
  assign bus_req_valid_o = (st_q != LC_IDLE);

  always_comb begin
    bus_req_cmd_o  = CMD_RD;
    bus_req_addr_o = pend_addr_q;
    bus_req_data_o = '0;
    case (st_q)
      LC_WB: begin
        bus_req_cmd_o  = CMD_WB;
        bus_req_addr_o = {la_tag_i, la_idx_o};
        bus_req_data_o = la_data_i;
      end
      LC_UPG:  bus_req_cmd_o = CMD_UPG;
      LC_FILL: bus_req_cmd_o = pend_wr_q ? CMD_RDX : CMD_RD;
      default: ;
    endcase
  end
endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              bus_req_valid_o,
  output logic [1:0]        bus_req_cmd_o,
  output logic [ADDR_W-1:0] bus_req_addr_o,
  output logic [DATA_W-1:0] bus_req_data_o,
  input  logic              bus_done_i,
  input  logic              bus_shared_i,
  input  logic [DATA_W-1:0] bus_fill_data_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_inter_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  la_idx, sn_idx;
  logic [TAG_W-1:0]  la_tag, sn_tag, lw_tag;
  line_st_e          la_st, sn_st, lw_st, sw_st;
  logic [DATA_W-1:0] la_data, sn_data, lw_data;
  logic              lw_en, lw_data_en, sw_en;

  assign sn_idx = snp_addr_i[IDX_W-1:0];

  moesi_line_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk_i, .rst_ni,
    .la_idx_i(la_idx), .la_tag_o(la_tag), .la_st_o(la_st), .la_data_o(la_data),
    .sn_idx_i(sn_idx), .sn_tag_o(sn_tag), .sn_st_o(sn_st), .sn_data_o(sn_data),
    .lw_en_i(lw_en), .lw_idx_i(la_idx), .lw_tag_i(lw_tag), .lw_st_i(lw_st),
    .lw_data_en_i(lw_data_en), .lw_data_i(lw_data),
    .sw_en_i(sw_en), .sw_idx_i(sn_idx), .sw_st_i(sw_st)
  );

  moesi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid_i, .snp_cmd_i,
    .snp_tag_i(snp_addr_i[ADDR_W-1:IDX_W]),
    .line_tag_i(sn_tag), .line_st_i(sn_st), .line_data_i(sn_data),
    .shared_o(snp_shared_o), .inter_o(snp_inter_o), .data_o(snp_data_o),
    .upd_en_o(sw_en), .upd_st_o(sw_st)
  );

  moesi_local_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_local (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i, .req_ready_o,
    .rsp_valid_o, .rsp_rdata_o, .snp_valid_i,
    .bus_done_i, .bus_shared_i, .bus_fill_data_i,
    .bus_req_valid_o, .bus_req_cmd_o, .bus_req_addr_o, .bus_req_data_o,
    .la_idx_o(la_idx), .la_tag_i(la_tag), .la_st_i(la_st), .la_data_i(la_data),
    .lw_en_o(lw_en), .lw_tag_o(lw_tag), .lw_st_o(lw_st),
    .lw_data_en_o(lw_data_en), .lw_data_o(lw_data)
  );
endmodule

// File: rtl/moesi_snoop_ctrl_chk.sv
module moesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              snp_valid_i,
  input logic [1:0]        snp_cmd_i,
  input logic              snp_shared_o,
  input logic              snp_inter_o,
  input logic              req_ready_o,
  input logic              bus_req_valid_o,
  input logic [1:0]        bus_req_cmd_o,
  input logic [ADDR_W-1:0] bus_req_addr_o,
  input logic              bus_done_i,
  input logic              rsp_valid_o
);
  p_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_valid_o |-> !req_ready_o);

  p_snoop_prio_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !req_ready_o);

  p_snoop_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> (!snp_shared_o && !snp_inter_o));

  p_inter_shared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == 2'd0 && snp_inter_o) |-> snp_shared_o);

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_valid_o && !bus_done_i) |=>
      (bus_req_valid_o && $stable(bus_req_addr_o) && $stable(bus_req_cmd_o)));

  p_wb_then_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_valid_o && bus_done_i && bus_req_cmd_o == 2'd3) |=> bus_req_valid_o);

  p_fill_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_valid_o && bus_done_i && (bus_req_cmd_o == 2'd0 || bus_req_cmd_o == 2'd1))
      |=> rsp_valid_o);
endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .snp_valid_i(snp_valid_i), .snp_cmd_i(snp_cmd_i),
  .snp_shared_o(snp_shared_o), .snp_inter_o(snp_inter_o), .req_ready_o(req_ready_o),
  .bus_req_valid_o(bus_req_valid_o), .bus_req_cmd_o(bus_req_cmd_o),
  .bus_req_addr_o(bus_req_addr_o), .bus_done_i(bus_done_i), .rsp_valid_o(rsp_valid_o)
);

// File: tb/moesi_snoop_ctrl_bench.sv
module moesi_snoop_ctrl_bench;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [1:0] RD = 2'd0, RDX = 2'd1, UPG = 2'd2, WB = 2'd3;
  localparam logic [AW-1:0] A = 12'h020, B = 12'h120, C = 12'h003, D = 12'h005, E = 12'h006;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic [DW-1:0] bus_req_data;
  logic bus_done = 0, bus_shared = 0;
  logic [DW-1:0] bus_fill = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_inter;
  logic [DW-1:0] snp_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  moesi_snoop_ctrl u_moesi_snoop_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_req_valid_o(bus_req_valid), .bus_req_cmd_o(bus_req_cmd),
    .bus_req_addr_o(bus_req_addr), .bus_req_data_o(bus_req_data),
    .bus_done_i(bus_done), .bus_shared_i(bus_shared), .bus_fill_data_i(bus_fill),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_inter_o(snp_inter), .snp_data_o(snp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    #1 chk(req_ready, "R11 idle accept", {31'd0, req_ready}, 1);
    @(negedge clk);
    req_valid = 0;
    #1;
  endtask

  task automatic serve(input logic [1:0] cmd, input logic [AW-1:0] a, input bit sh,
                       input logic [DW-1:0] fill, input string req);
    chk(bus_req_valid, req, {31'd0, bus_req_valid}, 1);
    chk(bus_req_cmd == cmd, req, {30'd0, bus_req_cmd}, {30'd0, cmd});
    chk(bus_req_addr == a, req, {20'd0, bus_req_addr}, {20'd0, a});
    chk(!req_ready, "R11 stall", {31'd0, req_ready}, 0);
    bus_done = 1; bus_shared = sh; bus_fill = fill;
    @(negedge clk);
    bus_done = 0; bus_shared = 0; bus_fill = '0;
    #1;
  endtask

  task automatic exp_rsp(input logic [DW-1:0] d, input string req);
    chk(rsp_valid, req, {31'd0, rsp_valid}, 1);
    chk(rsp_rdata == d, req, rsp_rdata, d);
  endtask

  task automatic hit(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [DW-1:0] exp, input string req);
    cpu(w, a, d);
    exp_rsp(exp, req);
    chk(!bus_req_valid, req, {31'd0, bus_req_valid}, 0);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input bit sh,
                       input bit inter, input logic [DW-1:0] d, input string req);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a;
    #1;
    chk(snp_shared == sh, req, {31'd0, snp_shared}, {31'd0, sh});
    chk(snp_inter == inter, req, {31'd0, snp_inter}, {31'd0, inter});
    if (inter) chk(snp_data == d, req, snp_data, d);
    chk(!req_ready, "R11 snoop first", {31'd0, req_ready}, 0);
    @(negedge clk);
    snp_valid = 0;
    #1;
  endtask

  // R1 reset state
  task automatic t_reset();
    #1;
    chk(req_ready && !bus_req_valid && !rsp_valid, "R1", {29'd0, req_ready, bus_req_valid, rsp_valid}, 3'b100);
    snoop(RD, A, 0, 0, '0, "R1");
  endtask

  // R2 exclusive fill, R8 E->S, R5 upgrade from S, R3 hits
  task automatic t_read_share();
    cpu(0, A, 0);
    serve(RD, A, 0, 32'h11, "R2");
    exp_rsp(32'h11, "R2");
    hit(0, A, 0, 32'h11, "R3");
    snoop(RD, A, 1, 0, '0, "R8 E");
    snoop(RD, A, 1, 0, '0, "R8 S");
    cpu(1, A, 32'hA1);
    serve(UPG, A, 0, 0, "R5 S");
    exp_rsp(32'hA1, "R5");
    hit(0, A, 0, 32'hA1, "R3 M");
  endtask

  // R7 owned, R3 hit in O, R5 upgrade from O
  task automatic t_owned();
    snoop(RD, A, 1, 1, 32'hA1, "R7 M");
    snoop(RD, A, 1, 1, 32'hA1, "R7 O");
    hit(0, A, 0, 32'hA1, "R3 O");
    cpu(1, A, 32'hA2);
    serve(UPG, A, 0, 0, "R5 O");
    exp_rsp(32'hA2, "R5");
  endtask

  // R10 dirty and clean victims, R13 snoop miss
  task automatic t_evict();
    cpu(0, B, 0);
    chk(bus_req_data == 32'hA2, "R10 wb data", bus_req_data, 32'hA2);
    serve(WB, A, 0, 0, "R10 wb");
    serve(RD, B, 1, 32'h22, "R10 fill");
    exp_rsp(32'h22, "R2 shared fill");
    snoop(RD, A, 0, 0, '0, "R13");
    cpu(0, A, 0);
    serve(RD, A, 1, 32'h33, "R10 silent");
    exp_rsp(32'h33, "R10");
    snoop(RD, B, 0, 0, '0, "R13");
  endtask

  // R9 invalidations, R4 silent E->M
  task automatic t_invalidate();
    snoop(UPG, A, 0, 0, '0, "R9 upg S");
    cpu(0, A, 0);
    serve(RD, A, 0, 32'h44, "R9");
    exp_rsp(32'h44, "R9");
    snoop(RDX, A, 0, 0, '0, "R9 rdx E");
    cpu(0, A, 0);
    serve(RD, A, 0, 32'h55, "R9");
    exp_rsp(32'h55, "R9");
    hit(1, A, 32'h66, 32'h66, "R4");
    snoop(RDX, A, 0, 1, 32'h66, "R9 rdx M");
    cpu(0, A, 0);
    serve(RD, A, 0, 32'h77, "R9");
    exp_rsp(32'h77, "R9");
  endtask

  // R6 write miss; R9 rdx on O
  task automatic t_write_miss();
    cpu(1, C, 32'hC0);
    serve(RDX, C, 0, 0, "R6");
    exp_rsp(32'hC0, "R6");
    hit(0, C, 0, 32'hC0, "R6");
    snoop(RD, C, 1, 1, 32'hC0, "R6 M");
    snoop(RDX, C, 0, 1, 32'hC0, "R9 rdx O");
    cpu(0, C, 0);
    serve(RD, C, 0, 32'h99, "R9");
    exp_rsp(32'h99, "R9");
  endtask

  // R12 upgrade lost to snoop
  task automatic t_upg_lost();
    cpu(0, D, 0);
    serve(RD, D, 1, 32'hD0, "R12");
    exp_rsp(32'hD0, "R12");
    cpu(1, D, 32'hD1);
    snoop(UPG, D, 0, 0, '0, "R12 inv");
    serve(UPG, D, 0, 0, "R12 upg");
    serve(RDX, D, 0, 0, "R12 rdx");
    exp_rsp(32'hD1, "R12");
    snoop(RD, D, 1, 1, 32'hD1, "R12 M");
  endtask

  // R11 snoop takes the cycle over a local request
  task automatic t_priority();
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = C;
    snp_valid = 1; snp_cmd = RD; snp_addr = E;
    #1 chk(!req_ready, "R11 prio", {31'd0, req_ready}, 0);
    chk(!snp_shared && !snp_inter, "R13", {30'd0, snp_shared, snp_inter}, 0);
    @(negedge clk);
    snp_valid = 0;
    #1 chk(req_ready && !rsp_valid, "R11 held", {30'd0, req_ready, rsp_valid}, 2'b10);
    @(negedge clk);
    req_valid = 0;
    #1 exp_rsp(32'h99, "R11 after snoop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_share();
    t_owned();
    t_evict();
    t_invalidate();
    t_write_miss();
    t_upg_lost();
    t_priority();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule